// File: doc/BRIEF.md
# Stream-Tagged Translation Cache with Masked Flush

This block holds a handful of recently used leaf translations in front of a page walker. Each entry is tagged by a 4-bit stream ID and a virtual page number, and it returns the physical page number. A lookup is answered in the same cycle. On a miss, the walker resolves the translation and writes it back through the fill port. When all entries are in use, entries are replaced in round-robin order.

Software reaches the block through a 32-bit register port. It first programs a 16-bit stream-select register, then issues a flush command. The flush visits one entry per clock and invalidates each valid entry whose stream bit is selected. While it runs, a busy bit reads back as 1, and software polls that bit until it clears. During the flush, lookups report a miss and fills are thrown away. After the flush, the cache is consistent with the page tables that software has just changed.

Top module: `xlat_cache`

## Requirements
- R1: After reset, no lookup hits, the busy bit (bit 2 at offset 0x20) reads 0 and the stream-select register (offset 0x34) reads 0.
- R2: A lookup hits and returns the stored physical page in the same cycle only when a valid entry matches both the stream ID and the virtual page. The same page under another stream misses.
- R3: A fill whose stream/page pair is not cached is written to the slot under a round-robin pointer. The pointer starts at slot 0 and advances modulo 8 on each such fill, so the ninth new translation evicts the first.
- R4: A fill whose stream/page pair is already cached overwrites that entry's physical page and leaves the round-robin pointer unchanged.
- R5: Offset 0x34 is read/write in bits [15:0], where bit n selects stream n. Bits [31:16] read 0.
- R6: A write to offset 0x20 with bit 20 set while idle starts a flush. The busy bit then reads 1 for exactly 8 cycles, starting with the cycle after the write.
- R7: When a flush ends, every entry whose stream bit was selected is invalid and every other entry still hits with its old page.
- R8: While busy, every lookup reports a miss and fill requests are dropped.
- R9: A flush command written while busy is ignored and does not lengthen the busy period.
- R10: A flush uses the stream selection present when it starts. A write to 0x34 during a flush takes effect for later flushes only.
- R11: A write to offset 0x20 with bit 20 clear does not start a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_sid_i | input | 4 | Lookup stream ID |
| lkp_vpn_i | input | 20 | Lookup virtual page number |
| lkp_hit_o | output | 1 | Lookup hit (same cycle) |
| lkp_ppn_o | output | 24 | Physical page number on hit, 0 otherwise |
| fill_valid_i | input | 1 | Fill request from walker |
| fill_sid_i | input | 4 | Fill stream ID |
| fill_vpn_i | input | 20 | Fill virtual page number |
| fill_ppn_i | input | 24 | Fill physical page number |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |

## Verification
The flush is swept across every single-stream selection, plus all streams, no streams and the two alternating-bit patterns. In each round, eight entries are loaded with stream IDs in a rotating pattern, so each selection hits a different subset. Single-bit selections show that the stream decode is exact. The all and none patterns check the two extremes, and the alternating patterns reveal an inverted or shifted mask. One extra flush carries interference while busy: a second command, a rewrite of the stream selection, a fill and a lookup. This flush separates the captured selection from the live one and shows whether busy is held for exactly eight cycles. Before the flush tests, a fill sequence covers round-robin eviction and in-place update, and cross-stream lookups check tag separation.

// File: rtl/xlat_cache_pkg.sv
`timescale 1ns/1ps
package xlat_cache_pkg;
  localparam int unsigned OP_OFS    = 32'h20;
  localparam int unsigned MASK_OFS  = 32'h34;
  localparam int unsigned FLUSH_BIT = 20;
  localparam int unsigned BUSY_BIT  = 2;
  localparam int unsigned REG_W     = 32;
endpackage

// File: rtl/xlat_cache_regs.sv
`timescale 1ns/1ps
module xlat_cache_regs
  import xlat_cache_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 16,
  parameter int unsigned ADDR_W      = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_we_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [REG_W-1:0]       reg_wdata_i,
  output logic [REG_W-1:0]       reg_rdata_o,
  input  logic                   busy_i,
  output logic [NUM_STREAMS-1:0] mask_o,
  output logic                   start_o
);
  logic [NUM_STREAMS-1:0] mask_q;
  logic                   op_sel, mask_sel;
  logic                   unused_wdata;

  assign op_sel       = (reg_addr_i == ADDR_W'(OP_OFS));
  assign mask_sel     = (reg_addr_i == ADDR_W'(MASK_OFS));
  assign unused_wdata = ^reg_wdata_i;

  // flush request only accepted while idle
  assign start_o = reg_we_i && op_sel && reg_wdata_i[FLUSH_BIT] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   mask_q <= '0;
    else if (reg_we_i && mask_sel) mask_q <= reg_wdata_i[NUM_STREAMS-1:0];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (op_sel)        reg_rdata_o[BUSY_BIT] = busy_i;
    else if (mask_sel) reg_rdata_o[NUM_STREAMS-1:0] = mask_q;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/xlat_cache_flush.sv
`timescale 1ns/1ps
module xlat_cache_flush #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned NUM_STREAMS = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [NUM_STREAMS-1:0] mask_i,
  output logic                   busy_o,
  output logic                   clr_en_o,
  output logic [IDX_W-1:0]       clr_idx_o,
  output logic [NUM_STREAMS-1:0] clr_mask_o
);
  logic                   busy_q;
  logic [IDX_W-1:0]       idx_q;
  logic [NUM_STREAMS-1:0] mask_q;
  logic                   last;

  assign last = (idx_q == IDX_W'(NUM_ENTRIES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      mask_q <= mask_i;  // selection frozen for the whole walk
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign clr_en_o   = busy_q;
  assign clr_idx_o  = idx_q;
  assign clr_mask_o = mask_q;
endmodule

// File: rtl/xlat_cache_array.sv
`timescale 1ns/1ps
module xlat_cache_array #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned NUM_STREAMS = 16,
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned PPN_W       = 24,
  localparam int unsigned SID_W      = $clog2(NUM_STREAMS),
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   blocked_i,
  input  logic                   lkp_valid_i,
  input  logic [SID_W-1:0]       lkp_sid_i,
  input  logic [VPN_W-1:0]       lkp_vpn_i,
  output logic                   lkp_hit_o,
  output logic [PPN_W-1:0]       lkp_ppn_o,
  input  logic                   fill_valid_i,
  input  logic [SID_W-1:0]       fill_sid_i,
  input  logic [VPN_W-1:0]       fill_vpn_i,
  input  logic [PPN_W-1:0]       fill_ppn_i,
  input  logic                   clr_en_i,
  input  logic [IDX_W-1:0]       clr_idx_i,
  input  logic [NUM_STREAMS-1:0] clr_mask_i,
  output logic [NUM_ENTRIES-1:0] valid_o
);
  logic [NUM_ENTRIES-1:0] valid_q;
  logic [SID_W-1:0]       sid_q [NUM_ENTRIES];
  logic [VPN_W-1:0]       vpn_q [NUM_ENTRIES];
  logic [PPN_W-1:0]       ppn_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] lkp_match, fill_match;
  logic [IDX_W-1:0]       rr_q;
  logic                   fill_en, fill_hit;

  assign fill_en  = fill_valid_i && !blocked_i;
  assign fill_hit = |fill_match;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic sel_fill, sel_clr;

    assign lkp_match[i]  = valid_q[i] && (sid_q[i] == lkp_sid_i) && (vpn_q[i] == lkp_vpn_i);
    assign fill_match[i] = valid_q[i] && (sid_q[i] == fill_sid_i) && (vpn_q[i] == fill_vpn_i);
    assign sel_fill = fill_en && (fill_hit ? fill_match[i] : (rr_q == IDX_W'(i)));
    assign sel_clr  = clr_en_i && (clr_idx_i == IDX_W'(i)) && clr_mask_i[sid_q[i]];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        sid_q[i]   <= '0;
        vpn_q[i]   <= '0;
        ppn_q[i]   <= '0;
      end else if (sel_clr) begin
        valid_q[i] <= 1'b0;
      end else if (sel_fill) begin
        valid_q[i] <= 1'b1;
        sid_q[i]   <= fill_sid_i;
        vpn_q[i]   <= fill_vpn_i;
        ppn_q[i]   <= fill_ppn_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (fill_en && !fill_hit)
      rr_q <= (rr_q == IDX_W'(NUM_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  // tags are unique, so an OR of the gated pages is a one-hot mux
  always_comb begin
    lkp_ppn_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (lkp_match[i]) lkp_ppn_o = lkp_ppn_o | ppn_q[i];
    lkp_hit_o = lkp_valid_i && !blocked_i && (|lkp_match);
    if (!lkp_hit_o) lkp_ppn_o = '0;
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned NUM_STREAMS = 16,
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned PPN_W       = 24,
  parameter int unsigned ADDR_W      = 8,
  localparam int unsigned SID_W      = $clog2(NUM_STREAMS),
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [SID_W-1:0]  lkp_sid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  output logic              lkp_hit_o,
  output logic [PPN_W-1:0]  lkp_ppn_o,
  input  logic              fill_valid_i,
  input  logic [SID_W-1:0]  fill_sid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);
  logic                   busy, start, clr_en;
  logic [NUM_STREAMS-1:0] sel_mask, clr_mask;
  logic [IDX_W-1:0]       clr_idx;
  logic [NUM_ENTRIES-1:0] valid_vec;

  xlat_cache_regs #(.NUM_STREAMS(NUM_STREAMS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .mask_o(sel_mask), .start_o(start)
  );

  xlat_cache_flush #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_STREAMS(NUM_STREAMS)) u_flush (
    .clk_i, .rst_ni, .start_i(start), .mask_i(sel_mask), .busy_o(busy),
    .clr_en_o(clr_en), .clr_idx_o(clr_idx), .clr_mask_o(clr_mask)
  );

  xlat_cache_array #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_STREAMS(NUM_STREAMS), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_array (
    .clk_i, .rst_ni, .blocked_i(busy),
    .lkp_valid_i, .lkp_sid_i, .lkp_vpn_i, .lkp_hit_o, .lkp_ppn_o,
    .fill_valid_i, .fill_sid_i, .fill_vpn_i, .fill_ppn_i,
    .clr_en_i(clr_en), .clr_idx_i(clr_idx), .clr_mask_i(clr_mask), .valid_o(valid_vec)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
`timescale 1ns/1ps
module xlat_cache_chk
  import xlat_cache_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned ADDR_W      = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   busy,
  input logic [NUM_ENTRIES-1:0] valid_vec,
  input logic                   lkp_hit_o,
  input logic                   fill_valid_i,
  input logic                   reg_we_i,
  input logic [ADDR_W-1:0]      reg_addr_i,
  input logic [REG_W-1:0]       reg_wdata_i,
  input logic [REG_W-1:0]       reg_rdata_o
);
  localparam int unsigned CNT_W = $clog2(NUM_ENTRIES) + 2;
  logic [CNT_W-1:0] busy_cnt;
  logic             flush_wr;

  assign flush_wr = reg_we_i && (reg_addr_i == ADDR_W'(OP_OFS)) && reg_wdata_i[FLUSH_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  p_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_wr && !busy |=> busy);
  p_busy_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> busy_cnt < CNT_W'(NUM_ENTRIES));
  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $past(busy_cnt) == CNT_W'(NUM_ENTRIES - 1));
  p_rise_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(flush_wr));
  p_no_hit_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !lkp_hit_o);
  p_fill_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && fill_valid_i |=> (valid_vec & ~$past(valid_vec)) == '0);
  p_mask_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == ADDR_W'(MASK_OFS) |-> reg_rdata_o[31:16] == 16'h0);
endmodule

bind xlat_cache xlat_cache_chk #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy), .valid_vec(valid_vec),
  .lkp_hit_o(lkp_hit_o), .fill_valid_i(fill_valid_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
  localparam int N = 8;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        lkp_valid_i = 1'b0, fill_valid_i = 1'b0, reg_we_i = 1'b0;
  logic [3:0]  lkp_sid_i = '0, fill_sid_i = '0;
  logic [19:0] lkp_vpn_i = '0, fill_vpn_i = '0;
  logic [23:0] fill_ppn_i = '0, lkp_ppn_o;
  logic        lkp_hit_o;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;

  always #5 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk_i(clk), .rst_ni, .lkp_valid_i, .lkp_sid_i, .lkp_vpn_i, .lkp_hit_o, .lkp_ppn_o,
    .fill_valid_i, .fill_sid_i, .fill_vpn_i, .fill_ppn_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  bit          m_v   [N];
  logic [3:0]  m_sid [N];
  logic [19:0] m_vpn [N];
  logic [23:0] m_ppn [N];
  int          m_rr = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_fill(input logic [3:0] s, input logic [19:0] v, input logic [23:0] p);
    for (int e = 0; e < N; e++)
      if (m_v[e] && m_sid[e] == s && m_vpn[e] == v) begin
        m_ppn[e] = p;
        return;
      end
    m_v[m_rr] = 1'b1; m_sid[m_rr] = s; m_vpn[m_rr] = v; m_ppn[m_rr] = p;
    m_rr = (m_rr + 1) % N;
  endtask

  task automatic model_flush(input logic [15:0] m);
    for (int e = 0; e < N; e++)
      if (m_v[e] && m[m_sid[e]]) m_v[e] = 1'b0;
  endtask

  task automatic do_fill(input logic [3:0] s, input logic [19:0] v, input logic [23:0] p);
    @(negedge clk);
    fill_valid_i = 1'b1; fill_sid_i = s; fill_vpn_i = v; fill_ppn_i = p;
    @(posedge clk); #1;
    fill_valid_i = 1'b0;
    model_fill(s, v, p);
  endtask

  task automatic look(input logic [3:0] s, input logic [19:0] v, input string tag);
    bit          eh = 1'b0;
    logic [23:0] ep = '0;
    for (int e = 0; e < N; e++)
      if (m_v[e] && m_sid[e] == s && m_vpn[e] == v) begin eh = 1'b1; ep = m_ppn[e]; end
    @(negedge clk);
    lkp_valid_i = 1'b1; lkp_sid_i = s; lkp_vpn_i = v;
    #1;
    chk(lkp_hit_o == eh, tag, 32'(lkp_hit_o), 32'(eh));
    chk(lkp_ppn_o == ep, tag, 32'(lkp_ppn_o), 32'(ep));
    lkp_valid_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr_i = a;
    #1;
    chk(reg_rdata_o == exp, tag, reg_rdata_o, exp);
  endtask

  // start a flush; busy must read 1 for N cycles then 0. busy_mode adds interference
  task automatic flush_run(input logic [15:0] m, input bit busy_mode);
    wr(8'h20, 32'h0010_0000);
    for (int k = 0; k <= N; k++) begin
      @(negedge clk);
      reg_addr_i = 8'h20;
      if (busy_mode && k == 2) begin reg_we_i = 1'b1; reg_wdata_i = 32'h0010_0000; end
      if (busy_mode && k == 3) begin reg_we_i = 1'b1; reg_addr_i = 8'h34; reg_wdata_i = 32'h0; end
      if (busy_mode && k == 4) begin
        fill_valid_i = 1'b1; fill_sid_i = 4'hF; fill_vpn_i = 20'hFFFFF; fill_ppn_i = 24'h123456;
      end
      if (busy_mode && k == 5) begin lkp_valid_i = 1'b1; lkp_sid_i = m_sid[7]; lkp_vpn_i = m_vpn[7]; end
      #1;
      if (reg_addr_i == 8'h20)
        chk(reg_rdata_o[2] == (k < N), busy_mode ? "R9 busy not extended" : "R6 busy length",
            32'(reg_rdata_o[2]), 32'(k < N));
      if (busy_mode && k == 5) chk(lkp_hit_o == 1'b0, "R8 lookup misses while busy", 32'(lkp_hit_o), 0);
      @(posedge clk); #1;
      reg_we_i = 1'b0; fill_valid_i = 1'b0; lkp_valid_i = 1'b0;
    end
    model_flush(m);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [19:0] base;
    for (int e = 0; e < N; e++) m_v[e] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(8'h20, 32'h0, "R1 busy after reset");
    rd(8'h34, 32'h0, "R1 mask after reset");
    look(4'h0, 20'h0, "R1 no hit after reset");

    // R2 hits and stream separation
    for (int i = 0; i < N; i++) do_fill(4'(i * 2), 20'(i * 17 + 3), 24'(i * 257 + 5));
    for (int i = 0; i < N; i++) begin
      look(4'(i * 2), 20'(i * 17 + 3), "R2 hit");
      look(4'(i * 2 + 1), 20'(i * 17 + 3), "R2 other stream misses");
    end

    // R3 ninth new fill evicts slot 0
    do_fill(4'h9, 20'h0ABCD, 24'hBEEF01);
    look(4'h0, 20'd3, "R3 evicted first entry");
    look(4'h9, 20'h0ABCD, "R3 new entry hits");

    // R4 update in place, pointer unchanged (next new fill evicts slot 1)
    do_fill(4'd6, 20'(3 * 17 + 3), 24'h00C0DE);
    look(4'd6, 20'(3 * 17 + 3), "R4 updated page");
    do_fill(4'hA, 20'h0BEEF, 24'h777777);
    look(4'd2, 20'(1 * 17 + 3), "R4 pointer not advanced by update");
    look(4'd4, 20'(2 * 17 + 3), "R4 slot 2 survives");

    // R5 mask register
    wr(8'h34, 32'hFFFF_A5C3);
    rd(8'h34, 32'h0000_A5C3, "R5 mask readback");

    // R11 op write without flush bit
    wr(8'h20, 32'h0000_0004);
    rd(8'h20, 32'h0, "R11 no flush without bit 20");
    look(4'h9, 20'h0ABCD, "R11 entries intact");

    // R6/R7 flush sweep over stream selections
    base = 20'h10000;
    for (int r = 0; r < 20; r++) begin
      logic [15:0] m;
      m = (r < 16) ? 16'(1 << r) : (r == 16) ? 16'hFFFF : (r == 17) ? 16'h0000 :
          (r == 18) ? 16'hAAAA : 16'h5555;
      for (int i = 0; i < N; i++)
        do_fill(4'((i * 5 + r) % 16), base + 20'(i), 24'((base + 20'(i)) * 3) ^ 24'hABC);
      wr(8'h34, 32'(m));
      flush_run(m, 1'b0);
      for (int i = 0; i < N; i++)
        look(4'((i * 5 + r) % 16), base + 20'(i), "R7 selective flush result");
      base = base + 20'h10;
    end

    // R8/R9/R10 interference during a flush
    for (int i = 0; i < N; i++)
      do_fill(4'(i * 2), base + 20'(i), 24'(i + 1));
    wr(8'h34, 32'h0000_00F0);
    flush_run(16'h00F0, 1'b1);
    rd(8'h34, 32'h0, "R10 mask write during flush landed");
    for (int i = 0; i < N; i++)
      look(4'(i * 2), base + 20'(i), "R10 flush used captured mask");
    look(4'hF, 20'hFFFFF, "R8 fill during flush dropped");
    rd(8'h20, 32'h0, "R9 idle after ignored command");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule